// File: doc/BRIEF.md
# Manchester II Word Encoder

This block turns one 16-bit word into a serial Manchester II waveform for a dual-redundant command/response data bus. A host write hands over the word together with two choices: which sync pattern goes in front of it (command/status or data), and which of the two buses, A or B, carries it. Both choices are captured in the same clock edge that accepts the word. From then on the block runs by itself and the host inputs have no effect until the word is done.

Each transmission lasts 20 bit times. It has a 3-bit-time sync, then the 16 data bits with the most significant bit first, then a parity bit that the block computes so that the 16 data bits and the parity bit together hold an odd number of ones. The bit period is the system clock frequency divided by the bit rate, which gives 12 clocks per bit and 6 clocks per half-bit at 12 MHz. The waveform leaves the block as a pair of drive enables for each bus, one positive and one negative. On the selected bus exactly one of the pair is high while a word is in progress. An analog line driver outside the block turns the enables into the differential bus signal.

Top module: `mnc_word_encoder`

## Requirements
- R1: The half-bit is CLK_HZ/BIT_HZ/2 clocks long (6 clocks at the default 12 MHz and 1 Mbit/s). Levels change only on half-bit boundaries counted from the cycle after the write.
- R2: With wr_cmd_sync=1 the sync is 18 clocks high followed by 18 clocks low. "High" means pos=1 and neg=0 on the selected bus, and "low" means pos=0 and neg=1.
- R3: With wr_cmd_sync=0 the sync is 18 clocks low followed by 18 clocks high.
- R4: After the sync, the 16 data bits are sent starting with wr_data[15]. A 1 bit is high for its first half-bit and low for its second half-bit, and a 0 bit is the reverse.
- R5: After the last data bit comes one parity bit, encoded like a data bit. Its value makes the total number of ones in the data plus parity odd.
- R6: The bus is latched at the write, with wr_bus_b=0 selecting bus A and wr_bus_b=1 selecting bus B. While busy, both enables of the other bus stay 0 and exactly one of the four enables is 1.
- R7: When the block is idle, all four drive enables are 0.
- R8: A write is accepted on a clock edge where wr_en=1 and busy=0. busy is 1 for exactly 240 cycles starting with the cycle after that edge, and the waveform occupies the same 240 cycles.
- R9: A write while busy=1 is ignored. The word in flight continues unchanged and no second word follows it.
- R10: Synchronous active-high rst returns the block to idle on the next clock edge, even in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the transmit word |
| wr_data | input | 16 | Word to transmit; bit 15 goes first |
| wr_cmd_sync | input | 1 | 1 = command/status sync, 0 = data sync |
| wr_bus_b | input | 1 | 0 = bus A, 1 = bus B |
| busy | output | 1 | A word is being transmitted |
| bus_a_pos | output | 1 | Bus A positive drive enable |
| bus_a_neg | output | 1 | Bus A negative drive enable |
| bus_b_pos | output | 1 | Bus B positive drive enable |
| bus_b_neg | output | 1 | Bus B negative drive enable |

## Verification
The assertions check on every cycle the properties that do not depend on the word's content. The half-bit counter stays in range. The line level holds between half-bit ticks. Once busy is set it stays set until the last slot ends. The latched bus does not move during a word. Exactly one enable is high while busy and none are high while idle. Only the bench scenarios can show that the waveform itself is right. They compare each of the 240 cycles against an expected level, computed separately for both sync types, for several data patterns with a high or low first bit, and for even and odd weights that produce parity 0 and 1. They also cover both buses, a write injected in the middle of a word, and a reset in the middle of a word.

// File: rtl/mnc_pkg.sv
package mnc_pkg;

    localparam int WORD_W      = 16;
    localparam int SYNC_HALVES = 6;
    localparam int SLOT_N      = SYNC_HALVES + 2 * (WORD_W + 1);

    typedef enum logic {
        BUS_A = 1'b0,
        BUS_B = 1'b1
    } bus_sel_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              cmd_sync;
        bus_sel_e          bus;
    } tx_req_t;

    // Odd parity over the data word: data plus parity carries an odd count of ones.
    function automatic logic odd_parity(input logic [WORD_W-1:0] d);
        return ~(^d);
    endfunction

    // Half-bit level sequence, first slot in the MSB.
    function automatic logic [SLOT_N-1:0] build_slots(input tx_req_t req);
        logic [SLOT_N-1:0] s;
        logic [WORD_W:0]   payload;
        s = '0;
        payload = {req.data, odd_parity(req.data)};
        for (int h = 0; h < SYNC_HALVES; h++) begin
            s[SLOT_N-1-h] = (h < SYNC_HALVES/2) ? req.cmd_sync : ~req.cmd_sync;
        end
        for (int b = 0; b <= WORD_W; b++) begin
            s[SLOT_N-1-SYNC_HALVES-2*b]     =  payload[WORD_W-b];
            s[SLOT_N-1-SYNC_HALVES-2*b-1]   = ~payload[WORD_W-b];
        end
        return s;
    endfunction

endpackage

// File: rtl/mnc_timebase.sv
module mnc_timebase #(
    parameter int HALF_CLKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    output logic half_tick
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF_CLKS - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign half_tick = run && (cnt == CW'(HALF_CLKS - 1));

    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(HALF_CLKS));

    p_cnt_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);

endmodule

// File: rtl/mnc_shifter.sv
module mnc_shifter
    import mnc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SLOT_N-1:0] slots_in,
    input  logic              half_tick,
    output logic              active,
    output logic              level
);
    localparam int SW = $clog2(SLOT_N);

    logic [SLOT_N-1:0] shreg;
    logic [SW-1:0]     slot;
    logic              last_slot;

    assign last_slot = (slot == SW'(SLOT_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '0;
            slot   <= '0;
            active <= 1'b0;
        end else if (load && !active) begin
            shreg  <= slots_in;
            slot   <= '0;
            active <= 1'b1;
        end else if (active && half_tick) begin
            shreg <= {shreg[SLOT_N-2:0], 1'b0};
            if (last_slot) begin
                active <= 1'b0;
                slot   <= '0;
            end else begin
                slot <= slot + 1'b1;
            end
        end
    end

    assign level = shreg[SLOT_N-1];

    p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
        active && !(half_tick && last_slot) |=> active);

    p_level_steady_r1: assert property (@(posedge clk) disable iff (rst)
        active && !half_tick |=> $stable(level));

    p_no_reload_r9: assert property (@(posedge clk) disable iff (rst)
        active && load && !half_tick |=> $stable(slot));

endmodule

// File: rtl/mnc_steer.sv
module mnc_steer
    import mnc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  bus_sel_e bus_in,
    input  logic     active,
    input  logic     level,
    output logic     a_pos,
    output logic     a_neg,
    output logic     b_pos,
    output logic     b_neg
);
    bus_sel_e bus_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q <= BUS_A;
        end else if (load && !active) begin
            bus_q <= bus_in;
        end
    end

    always_comb begin
        a_pos = 1'b0;
        a_neg = 1'b0;
        b_pos = 1'b0;
        b_neg = 1'b0;
        if (active) begin
            if (bus_q == BUS_B) begin
                b_pos =  level;
                b_neg = ~level;
            end else begin
                a_pos =  level;
                a_neg = ~level;
            end
        end
    end

    p_bus_locked_r9: assert property (@(posedge clk) disable iff (rst)
        active |=> $stable(bus_q));

    p_one_drive_r6: assert property (@(posedge clk) disable iff (rst)
        active |-> $countones({a_pos, a_neg, b_pos, b_neg}) == 1);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !active |-> {a_pos, a_neg, b_pos, b_neg} == 4'b0000);

endmodule

// File: rtl/mnc_word_encoder.sv
module mnc_word_encoder
    import mnc_pkg::*;
#(
    parameter int CLK_HZ = 12_000_000,
    parameter int BIT_HZ = 1_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_cmd_sync,
    input  logic              wr_bus_b,
    output logic              busy,
    output logic              bus_a_pos,
    output logic              bus_a_neg,
    output logic              bus_b_pos,
    output logic              bus_b_neg
);
    localparam int CLKS_PER_BIT = CLK_HZ / BIT_HZ;
    localparam int HALF_CLKS    = CLKS_PER_BIT / 2;

    tx_req_t           req;
    logic [SLOT_N-1:0] slots;
    logic              accept;
    logic              half_tick;
    logic              level;

    assign req.data     = wr_data;
    assign req.cmd_sync = wr_cmd_sync;
    assign req.bus      = wr_bus_b ? BUS_B : BUS_A;
    assign slots        = build_slots(req);
    assign accept       = wr_en && !busy;

    mnc_timebase #(
        .HALF_CLKS(HALF_CLKS)
    ) u_timebase (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .restart  (accept),
        .half_tick(half_tick)
    );

    mnc_shifter u_shifter (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_en),
        .slots_in (slots),
        .half_tick(half_tick),
        .active   (busy),
        .level    (level)
    );

    mnc_steer u_steer (
        .clk   (clk),
        .rst   (rst),
        .load  (wr_en),
        .bus_in(req.bus),
        .active(busy),
        .level (level),
        .a_pos (bus_a_pos),
        .a_neg (bus_a_neg),
        .b_pos (bus_b_pos),
        .b_neg (bus_b_neg)
    );

    p_start_r8: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    p_reset_idle_r10: assert property (@(posedge clk)
        rst |=> !busy);

endmodule

// File: tb/mnc_word_encoder_bench.sv
module mnc_word_encoder_bench;

    localparam int HALF    = 6;
    localparam int WORD_CY = 240;

    // {bus_b, cmd_sync, data}
    localparam logic [17:0] VECS [6] = '{
        {1'b0, 1'b1, 16'hA5C3},
        {1'b1, 1'b0, 16'h0001},
        {1'b0, 1'b0, 16'hFFFF},
        {1'b1, 1'b1, 16'h0000},
        {1'b0, 1'b1, 16'h8000},
        {1'b1, 1'b0, 16'h7FFE}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_cmd_sync = 1'b0;
    logic        wr_bus_b = 1'b0;
    logic        busy, bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mnc_word_encoder u_mnc_word_encoder (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_cmd_sync(wr_cmd_sync),
        .wr_bus_b   (wr_bus_b),
        .busy       (busy),
        .bus_a_pos  (bus_a_pos),
        .bus_a_neg  (bus_a_neg),
        .bus_b_pos  (bus_b_pos),
        .bus_b_neg  (bus_b_neg)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Expected line level at cycle k of a word, from the requirements.
    function automatic bit exp_level(input logic [15:0] d, input bit cmd, input int k);
        int  h;
        int  idx;
        bit  b;
        h = k / HALF;
        if (h < 6) return cmd ? (h < 3) : (h >= 3);
        idx = (h - 6) / 2;
        if (idx < 16) b = d[15-idx];
        else begin
            int ones = 0;
            for (int i = 0; i < 16; i++) ones += d[i];
            b = (ones % 2 == 0);
        end
        return ((h - 6) % 2 == 0) ? b : !b;
    endfunction

    function automatic string cat_of(input bit cmd, input int k);
        int h;
        h = k / HALF;
        if (h < 6) return cmd ? "R2" : "R3";
        if (h < 38) return "R4";
        return "R5";
    endfunction

    // Writes a word and checks all 240 cycles; optional mid-word write or reset.
    task automatic run_word(input logic [15:0] d, input bit cmd, input bit b,
                            input int inject_k, input int reset_k);
        int  bad_sync, bad_data, bad_par, bad_other, bad_busy;
        logic [3:0] act, exp;
        int  first_act [4];
        int  first_exp [4];
        bad_sync = 0; bad_data = 0; bad_par = 0; bad_other = 0; bad_busy = 0;
        for (int i = 0; i < 4; i++) begin first_act[i] = 0; first_exp[i] = 0; end
        @(negedge clk);
        wr_data = d; wr_cmd_sync = cmd; wr_bus_b = b; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        for (int k = 0; k < WORD_CY; k++) begin
            if (k > 0) @(negedge clk);
            if (k == reset_k) begin
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                chk(busy == 1'b0, "R10", "busy after mid-word reset", busy, 0);
                chk({bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg} == 4'b0, "R10",
                    "drives after mid-word reset",
                    {bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg}, 0);
                return;
            end
            if (k == inject_k) begin
                wr_data = ~d; wr_cmd_sync = !cmd; wr_bus_b = !b; wr_en = 1'b1;
            end
            if (k == inject_k + 1) wr_en = 1'b0;
            act = {bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg};
            if (b) exp = {2'b00, exp_level(d, cmd, k), !exp_level(d, cmd, k)};
            else   exp = {exp_level(d, cmd, k), !exp_level(d, cmd, k), 2'b00};
            if (busy !== 1'b1) bad_busy++;
            if ((b ? act[3:2] : act[1:0]) != 2'b00) bad_other++;
            if (act != exp) begin
                string c;
                int    ci;
                c  = cat_of(cmd, k);
                ci = (c == "R5") ? 2 : (c == "R4") ? 1 : 0;
                if (ci == 0) bad_sync++; else if (ci == 1) bad_data++; else bad_par++;
                if (first_act[ci] == 0 && first_exp[ci] == 0) begin
                    first_act[ci] = 32'h100 | act | (k << 12);
                    first_exp[ci] = 32'h100 | exp | (k << 12);
                end
            end
        end
        chk(bad_sync == 0, cmd ? "R2" : "R3", "sync pattern (k<<12|drives)", first_act[0], first_exp[0]);
        chk(bad_data == 0, "R4", "data bits (k<<12|drives)", first_act[1], first_exp[1]);
        chk(bad_par == 0, "R5", "parity bit (k<<12|drives)", first_act[2], first_exp[2]);
        chk(bad_other == 0, "R6", "unselected bus quiet, bad cycles", bad_other, 0);
        chk(bad_busy == 0, "R8", "busy held for 240 cycles, bad cycles", bad_busy, 0);
        @(negedge clk);
        chk(busy == 1'b0, "R8", "busy clear after 240 cycles", busy, 0);
        chk({bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg} == 4'b0, "R7",
            "idle drives after word", {bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg}, 0);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7", "busy after reset", busy, 0);
        chk({bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg} == 4'b0, "R7",
            "drives after reset", {bus_a_pos, bus_a_neg, bus_b_pos, bus_b_neg}, 0);

        foreach (VECS[i]) begin
            run_word(VECS[i][15:0], VECS[i][16], VECS[i][17], -1, -1);
        end

        // R1: exact half-bit edge at cycles 41/42 for a word starting with a 1 bit
        @(negedge clk);
        wr_data = 16'h8000; wr_cmd_sync = 1'b0; wr_bus_b = 1'b0; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (41) @(negedge clk);
        chk(bus_a_pos == 1'b1, "R1", "first data half at cycle 41", bus_a_pos, 1);
        @(negedge clk);
        chk(bus_a_pos == 1'b0, "R1", "second data half at cycle 42", bus_a_pos, 0);
        repeat (WORD_CY - 42) @(negedge clk);
        chk(busy == 1'b0, "R8", "busy clear at cycle 240", busy, 0);

        // R9: write in mid-word is ignored, nothing follows
        run_word(16'h1234, 1'b1, 1'b0, 100, -1);
        quiet = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            if (busy || bus_a_pos || bus_a_neg || bus_b_pos || bus_b_neg) quiet++;
        end
        chk(quiet == 0, "R9", "no second word after ignored write, active cycles", quiet, 0);

        // R10: reset mid-word
        run_word(16'hC0DE, 1'b0, 1'b1, -1, 50);
        run_word(16'h0F0F, 1'b1, 1'b1, -1, -1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule